// File: doc/BRIEF.md
# Wide Port Address Grouper

A device with several phys must decide, at run time, which of its phys form a common port. Each phy reports when its identification exchange has finished and supplies the SAS address the attached peer sent. This block captures that peer address once per identification, compares the captured addresses across all phys, and gives each phy a port index. Phys that see the same peer share one port (a wide port). Phys that see different peers go to separate ports.

The port index is the number of the lowest-numbered identified phy that carries the same peer address, so a port keeps the same number while its lowest member stays up. For each possible port index the block also gives a member mask, and it raises a one-cycle pulse when the grouping may have changed. On the transmit side it hands every phy that may share a port the same local SAS address, and every other phy its own dedicated address.

Top module: `wide_port_grouper`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, every port ID field reads the invalid code, every member mask reads zero and the change pulse is low.
- R2: A phy whose identified flag is low has the invalid code in its port ID field, which is all ones over PID_W = clog2(N)+1 bits, and is set in no member mask.
- R3: Identified phys whose captured peer addresses are equal get the same port ID.
- R4: Identified phys whose captured peer addresses differ get different port IDs.
- R5: The port ID of an identified phy j equals the lowest index k at or below j for which phy k is identified and holds the same captured address. Port ID field j sits at bits [j*PID_W +: PID_W] and member mask bit p*N+j is set exactly when phy j has port ID p.
- R6: The peer address is captured in the cycle the identified flag of that phy rises; changes on that phy's address input while the flag stays high have no effect on the port IDs.
- R7: Lowering and raising a phy's identified flag again makes it capture a new peer address, and its grouping follows the new address.
- R8: A change of any identified flag at a clock edge shows up in the port IDs and masks two edges later, and the change pulse is high for exactly the cycle following that second edge.
- R9: While all identified flags hold steady the change pulse stays low, whatever the address inputs do.
- R10: The transmit address of phy j equals the common local address when the shareable bit of phy j is set, and phy j's dedicated address otherwise, without clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phy_ident_i | input | N | Per-phy flag: identification of the attached peer completed |
| peer_addr_i | input | N*ADDR_W | Per-phy peer SAS address from the received identification frame |
| local_addr_i | input | ADDR_W | Local SAS address used on all shareable phys |
| shareable_i | input | N | Per-phy flag: phy may join a port with other phys |
| unique_addr_i | input | N*ADDR_W | Per-phy dedicated local address for phys that may not share |
| tx_addr_o | output | N*ADDR_W | Per-phy local address to transmit |
| port_id_o | output | N*PID_W | Per-phy port index, all ones when the phy has no port |
| port_mask_o | output | N*N | Per-port member mask, bit p*N+j for phy j in port p |
| chg_pulse_o | output | 1 | One-cycle pulse after an identified flag changed |

## Verification
The bench drops the lowest member of a wide port to show that the port number moves to the next member; a design that kept a stale leader would report a port number belonging to an idle phy and a mask on the wrong row. It changes the address inputs of identified phys for many cycles, where a design that tracked the live bus instead of the captured value would regroup and pulse. It re-identifies a phy onto another peer, which a design without recapture would leave in its old port, and runs a long random phase with a small address pool so that equal addresses on non-adjacent phys, simultaneous flag changes and late joiners below an existing leader all occur, against a cycle model that catches any skew in the two-edge latency or the pulse.

// File: rtl/wpg_pkg.sv
// Package: shared helpers for the wide port grouper.
// Assumes: phy counts from 1 to 8.
package wpg_pkg;

    // Width of a port ID field: enough for every phy index plus one spare
    // bit so that the all-ones code never names a real phy.
    function automatic int pid_w(input int n);
        return $clog2(n) + 1;
    endfunction

endpackage

// File: rtl/wpg_capture.sv
// Module: wpg_capture
// Holds each phy's identified flag and the peer address seen on the cycle
// the flag rose. Assumes the address input is valid on that cycle; later
// values on the address input are disregarded until the flag drops.
module wpg_capture #(
    parameter int N      = 4,
    parameter int ADDR_W = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        ident_i,
    input  logic [N*ADDR_W-1:0] addr_i,
    output logic [N-1:0]        ident_q_o,
    output logic [N*ADDR_W-1:0] addr_q_o
);

    // Register the flags and latch the address on each rising flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ident_q_o <= '0;
            addr_q_o  <= '0;
        end else begin
            ident_q_o <= ident_i;
            for (int j = 0; j < N; j++) begin
                if (ident_i[j] && !ident_q_o[j]) begin
                    addr_q_o[j*ADDR_W +: ADDR_W] <= addr_i[j*ADDR_W +: ADDR_W];
                end
            end
        end
    end

    generate
        for (genvar g = 0; g < N; g++) begin : g_chk
            // R6: a phy identified on two consecutive edges keeps its address
            p_hold_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (ident_q_o[g] && $past(ident_q_o[g]))
                |-> $stable(addr_q_o[g*ADDR_W +: ADDR_W]));
        end
    endgenerate

endmodule

// File: rtl/wpg_group.sv
// Module: wpg_group
// Combinational grouping: compares every pair of captured addresses and
// picks, for each identified phy, the lowest identified phy with an equal
// address. Unidentified phys get the all-ones code.
// Assumes inputs come straight from registers (one compare plus one
// priority pass of logic depth before the output registers).
module wpg_group #(
    parameter int N      = 4,
    parameter int ADDR_W = 64,
    parameter int PID_W  = 3
) (
    input  logic [N-1:0]        ident_q_i,
    input  logic [N*ADDR_W-1:0] addr_q_i,
    output logic [N*PID_W-1:0]  pid_next_o
);

    localparam logic [PID_W-1:0] PID_NONE = {PID_W{1'b1}};

    // same[j][k] for k < j: captured addresses of phy j and phy k agree
    logic [N-1:0][N-1:0] same;
    logic [PID_W-1:0]    pid [N];

    generate
        for (genvar j = 0; j < N; j++) begin : g_row
            for (genvar k = 0; k < N; k++) begin : g_col
                if (k < j) begin : g_cmp
                    assign same[j][k] =
                        (addr_q_i[j*ADDR_W +: ADDR_W] == addr_q_i[k*ADDR_W +: ADDR_W]);
                end else begin : g_none
                    assign same[j][k] = 1'b0;
                end
            end
            assign pid_next_o[j*PID_W +: PID_W] = pid[j];
        end
    endgenerate

    // Priority pick: scan downward so the lowest matching phy wins.
    always_comb begin
        for (int j = 0; j < N; j++) begin
            pid[j] = PID_NONE;
            if (ident_q_i[j]) begin
                pid[j] = PID_W'(j);
                for (int k = N - 1; k >= 0; k--) begin
                    if (k < j && ident_q_i[k] && same[j][k]) begin
                        pid[j] = PID_W'(k);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/wpg_out.sv
// Module: wpg_out
// Registers the port IDs, builds the per-port member masks and raises the
// change pulse one edge after the registered flags changed.
// Assumes pid_next_i is derived from the same ident_q_i it is given.
module wpg_out #(
    parameter int N     = 4,
    parameter int PID_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N-1:0]       ident_q_i,
    input  logic [N*PID_W-1:0] pid_next_i,
    output logic [N*PID_W-1:0] port_id_o,
    output logic [N*N-1:0]     port_mask_o,
    output logic               chg_pulse_o
);

    localparam logic [PID_W-1:0] PID_NONE = {PID_W{1'b1}};

    logic [N-1:0]   ident_prev;
    logic [N*N-1:0] mask_next;

    // Member masks: row p collects every phy whose next port ID is p.
    always_comb begin
        for (int p = 0; p < N; p++) begin
            for (int j = 0; j < N; j++) begin
                mask_next[p*N + j] = (pid_next_i[j*PID_W +: PID_W] == PID_W'(p));
            end
        end
    end

    // Output registers and change detector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_id_o   <= {N{PID_NONE}};
            port_mask_o <= '0;
            ident_prev  <= '0;
            chg_pulse_o <= 1'b0;
        end else begin
            port_id_o   <= pid_next_i;
            port_mask_o <= mask_next;
            ident_prev  <= ident_q_i;
            chg_pulse_o <= (ident_q_i != ident_prev);
        end
    end

    // R8: a flag change at the capture stage is followed by a pulse
    p_pulse_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ident_q_i != $past(ident_q_i)) |=> chg_pulse_o);

    generate
        for (genvar g = 0; g < N; g++) begin : g_chk
            // R2: a phy not identified one stage back holds the invalid code
            p_idle_invalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
                !$past(ident_q_i[g]) |-> (port_id_o[g*PID_W +: PID_W] == PID_NONE));
            // R5: a port index never exceeds the member's own index
            p_leader_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (port_id_o[g*PID_W +: PID_W] != PID_NONE)
                |-> (int'(port_id_o[g*PID_W +: PID_W]) <= g));
            // R5: the leader of a port is itself in that port
            p_leader_self_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (port_id_o[g*PID_W +: PID_W] != PID_NONE)
                |-> (port_id_o[int'(port_id_o[g*PID_W +: PID_W])*PID_W +: PID_W]
                     == port_id_o[g*PID_W +: PID_W]));
        end
    endgenerate

endmodule

// File: rtl/wide_port_grouper.sv
// Module: wide_port_grouper (top)
// Groups phys into ports by comparing the peer addresses they captured and
// selects each phy's transmitted local address.
// Assumes 1 <= N <= 8; identified flags come from the link layers of the
// phys and are synchronous to clk.
module wide_port_grouper #(
    parameter int N      = 4,
    parameter int ADDR_W = 64,
    localparam int PID_W = wpg_pkg::pid_w(N)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        phy_ident_i,
    input  logic [N*ADDR_W-1:0] peer_addr_i,
    input  logic [ADDR_W-1:0]   local_addr_i,
    input  logic [N-1:0]        shareable_i,
    input  logic [N*ADDR_W-1:0] unique_addr_i,
    output logic [N*ADDR_W-1:0] tx_addr_o,
    output logic [N*PID_W-1:0]  port_id_o,
    output logic [N*N-1:0]      port_mask_o,
    output logic                chg_pulse_o
);

    logic [N-1:0]        ident_q;
    logic [N*ADDR_W-1:0] addr_q;
    logic [N*PID_W-1:0]  pid_next;

    // Capture stage: flags and first-seen peer addresses.
    wpg_capture #(.N(N), .ADDR_W(ADDR_W)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .ident_i   (phy_ident_i),
        .addr_i    (peer_addr_i),
        .ident_q_o (ident_q),
        .addr_q_o  (addr_q)
    );

    // Grouping stage: pairwise compare and lowest-index pick.
    wpg_group #(.N(N), .ADDR_W(ADDR_W), .PID_W(PID_W)) u_group (
        .ident_q_i  (ident_q),
        .addr_q_i   (addr_q),
        .pid_next_o (pid_next)
    );

    // Output stage: registered IDs, masks and change pulse.
    wpg_out #(.N(N), .PID_W(PID_W)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .ident_q_i   (ident_q),
        .pid_next_i  (pid_next),
        .port_id_o   (port_id_o),
        .port_mask_o (port_mask_o),
        .chg_pulse_o (chg_pulse_o)
    );

    // Transmit address select: common address where sharing is allowed.
    generate
        for (genvar g = 0; g < N; g++) begin : g_tx
            assign tx_addr_o[g*ADDR_W +: ADDR_W] =
                shareable_i[g] ? local_addr_i : unique_addr_i[g*ADDR_W +: ADDR_W];
        end
    endgenerate

endmodule

// File: tb/wide_port_grouper_test.sv
module wide_port_grouper_test;

    localparam int N      = 4;
    localparam int W      = 64;
    localparam int PW     = $clog2(N) + 1;
    localparam int CLK_NS = 10;
    localparam logic [PW-1:0] NONE = {PW{1'b1}};

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   phy_ident = '0;
    logic [N*W-1:0] peer_addr = '0;
    logic [W-1:0]   local_addr = 64'h5000_0C00_AAAA_0001;
    logic [N-1:0]   shareable = '1;
    logic [N*W-1:0] unique_addr = '0;
    logic [N*W-1:0] tx_addr;
    logic [N*PW-1:0] port_id;
    logic [N*N-1:0]  port_mask;
    logic            chg_pulse;

    int nvec = 0;
    int nfail = 0;
    bit started = 0;
    bit finished = 0;
    int pulse_seen = 0;

    wide_port_grouper #(.N(N), .ADDR_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .phy_ident_i(phy_ident), .peer_addr_i(peer_addr),
        .local_addr_i(local_addr), .shareable_i(shareable), .unique_addr_i(unique_addr),
        .tx_addr_o(tx_addr), .port_id_o(port_id), .port_mask_o(port_mask),
        .chg_pulse_o(chg_pulse)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] pid_of(input int j);
        return port_id[j*PW +: PW];
    endfunction

    // Reference model: behavioural, updated on each rising edge.
    logic [W-1:0]  m_addr [N];
    logic [N-1:0]  m_ident = '0;
    bit            m_chg = 0;
    logic [PW-1:0] e_pid [N];
    logic [N*N-1:0] e_mask = '0;
    bit            e_pulse = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < N; j++) e_pid[j] = NONE;
            e_mask = '0; e_pulse = 0; m_ident = '0; m_chg = 0;
        end else begin
            logic [N-1:0] nxt;
            e_pulse = m_chg;
            for (int j = 0; j < N; j++) begin
                e_pid[j] = NONE;
                if (m_ident[j]) begin
                    for (int k = j; k >= 0; k--)
                        if (m_ident[k] && m_addr[k] == m_addr[j]) e_pid[j] = PW'(k);
                end
            end
            e_mask = '0;
            for (int j = 0; j < N; j++)
                if (e_pid[j] != NONE) e_mask[int'(e_pid[j])*N + j] = 1'b1;
            nxt = phy_ident;
            m_chg = (nxt != m_ident);
            for (int j = 0; j < N; j++)
                if (nxt[j] && !m_ident[j]) m_addr[j] = peer_addr[j*W +: W];
            m_ident = nxt;
        end
    end

    // Compare against the model on every falling edge.
    always @(negedge clk) begin
        if (started && !finished) begin
            for (int j = 0; j < N; j++) begin
                chk($sformatf("%s pid phy%0d", e_pid[j] == NONE ? "R2" : "R5", j),
                    W'(pid_of(j)), W'(e_pid[j]));
                chk($sformatf("R10 tx phy%0d", j), tx_addr[j*W +: W],
                    shareable[j] ? local_addr : unique_addr[j*W +: W]);
            end
            chk("R5 mask", W'(port_mask), W'(e_mask));
            chk("R8 pulse", W'(chg_pulse), W'(e_pulse));
            if (chg_pulse) pulse_seen++;
        end
    end

    // Drive inputs a few time units after a rising edge.
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #3;
        end
    endtask

    task automatic set_phy(input int j, input bit id, input logic [W-1:0] a);
        phy_ident[j] = id;
        peer_addr[j*W +: W] = a;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    endtask

    localparam logic [W-1:0] A = 64'h5000_0A00_1111_2222;
    localparam logic [W-1:0] B = 64'h5000_0B00_3333_4444;
    localparam logic [W-1:0] C = 64'h5000_0C00_5555_6666;

    initial begin
        for (int j = 0; j < N; j++) unique_addr[j*W +: W] = 64'h5000_0D00_0000_0000 + W'(j);
        step(4);
        rst_n = 1'b1;
        started = 1;
        step(1);
        @(negedge clk);
        // R1: clean state right after reset release
        for (int j = 0; j < N; j++) chk("R1 pid after reset", W'(pid_of(j)), W'(NONE));
        chk("R1 mask after reset", W'(port_mask), '0);
        chk("R1 pulse after reset", W'(chg_pulse), '0);
        step(1);

        // R3: phys 0 and 2 see the same peer
        set_phy(0, 1, A); set_phy(2, 1, A);
        step(3); @(negedge clk);
        chk("R3 phy2 joins phy0", W'(pid_of(2)), W'(pid_of(0)));
        chk("R3 wide port id", W'(pid_of(2)), 0);

        // R4: phys 1 and 3 see distinct peers
        step(1);
        set_phy(1, 1, B); set_phy(3, 1, C);
        step(3); @(negedge clk);
        chk("R4 phy1 own port", W'(pid_of(1)), 1);
        chk("R4 phy3 own port", W'(pid_of(3)), 3);
        chk("R4 phy1 vs phy0 differ", W'(pid_of(1) != pid_of(0)), 1);

        // R6/R9: address bus churns, flags steady
        step(1);
        pulse_seen = 0;
        for (int i = 0; i < 12; i++) begin
            for (int j = 0; j < N; j++) peer_addr[j*W +: W] = (i % 2) ? B : A;
            step(1);
        end
        @(negedge clk);
        chk("R9 no pulse while flags steady", W'(pulse_seen), 0);
        chk("R6 phy1 keeps port", W'(pid_of(1)), 1);
        chk("R6 phy3 keeps port", W'(pid_of(3)), 3);
        chk("R6 phy2 keeps port", W'(pid_of(2)), 0);

        // R5: drop the leader, next member takes over
        step(1);
        set_phy(0, 0, A);
        step(3); @(negedge clk);
        chk("R5 new leader phy2", W'(pid_of(2)), 2);
        chk("R5 mask row2 holds phy2", W'(port_mask[2*N + 2]), 1);
        chk("R2 dropped phy0 invalid", W'(pid_of(0)), W'(NONE));

        // R7: phy0 re-identifies onto B and joins phy1's port as leader
        step(1);
        set_phy(0, 1, B);
        step(3); @(negedge clk);
        chk("R7 phy0 recaptured", W'(pid_of(0)), 0);
        chk("R7 phy1 follows phy0", W'(pid_of(1)), 0);

        // Random phase against the model
        step(1);
        for (int i = 0; i < 600; i++) begin
            for (int j = 0; j < N; j++) begin
                if ($urandom_range(7) == 0) phy_ident[j] = ~phy_ident[j];
                case ($urandom_range(2))
                    0: peer_addr[j*W +: W] = A;
                    1: peer_addr[j*W +: W] = B;
                    default: peer_addr[j*W +: W] = C;
                endcase
            end
            if ($urandom_range(15) == 0) shareable = N'($urandom);
            step(1);
        end
        step(3);
        finish_run();
    end

    initial begin
        #(CLK_NS * 20000);
        nfail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

endmodule